// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block holds four alarm registers (seconds, minutes, hours, day of month) and one interrupt-control register. It compares the stored alarm against the live BCD time fields from a real-time clock. The compare runs only on the clock's one-second tick. When the fields in use agree and the stored enable bit is set, the block drives a single-cycle interrupt pulse.

Bit 7 of each alarm register is a repeat mask, so no separate mode register is needed. The pattern of mask bits across the four registers decides which fields take part in the compare, and that sets the repeat period: monthly, daily, hourly, once a minute, or every second.

A host writes registers through a select/data port and reads them back through a combinational read port. A write carrying an out-of-range BCD value is dropped, and the register keeps its old contents.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, every alarm register and the interrupt-control register read 0x00, and `irq_pulse` is low.
- R2: A write to seconds (select 0) or minutes (select 1) is taken only when bits 6:0 hold valid BCD from 00 to 59. When it is taken, the full byte is stored, including bit 7. Any other write leaves the register unchanged.
- R3: A write to hours (select 2) is taken only when bits 5:0 hold valid BCD from 00 to 23. Any other write leaves the register unchanged.
- R4: A write to date (select 3) is taken only when bits 4:0 hold a BCD value whose units digit is at most 9 and whose value is not zero. Any other write leaves the register unchanged.
- R5: Selects 0 to 3 read back the alarm registers exactly as stored, with bit 7 included. Select 4 reads back the interrupt-control byte as written. Selects 5 to 7 read 0x00, and writes to them change nothing.
- R6: With no mask bit set, the alarm fires only when date (bits 4:0), hours (bits 5:0), minutes and seconds (bits 6:0) all equal the current time.
- R7: With only the date mask set, the alarm fires when hours, minutes and seconds match, whatever the date.
- R8: With the date and hours masks set, and the other two clear, the alarm fires when minutes and seconds match.
- R9: With the date, hours and minutes masks set, and the seconds mask clear, the alarm fires when seconds match.
- R10: Every other mask combination fires on every tick.
- R11: The comparison is made only in a cycle where `tick` is high. `irq_pulse` is high for exactly the one following cycle.
- R12: `irq_pulse` is produced only while bit 7 of the interrupt-control register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register select |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Read register select |
| rd_data | output | 8 | Read data (combinational) |
| tick | input | 1 | One-second strobe, one cycle wide |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| irq_pulse | output | 1 | Alarm interrupt pulse |

## Verification
The bench targets the mask-pattern decode with a table of alarm settings and times. Each of the five repeat rates gets hits and near-misses where exactly one compared field differs. A design that decoded the masks per field instead of as a pattern would fire on the non-prefix combinations only when fields happen to match, or would keep comparing a masked field.

The bench drives boundary writes (59/60, 23/24, a date of zero, non-decimal digits). A validator off by one would corrupt a stored alarm.

Further directed cases cover three more faults:
- A design that evaluated the compare without a tick would pulse while the time sits still.
- A design that ignored the enable bit would interrupt a masked-off host.
- A design that stripped bit 7 on store would lose the repeat setting on readback.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  localparam int NF = 4;   // number of alarm fields
  localparam int DW = 8;   // register width

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  // significant low bits, and legal decimal range, per field
  localparam int FLD_BITS [NF] = '{7, 7, 6, 5};
  localparam int FLD_LO   [NF] = '{0, 0, 0, 1};
  localparam int FLD_HI   [NF] = '{59, 59, 23, 31};

  localparam int MASK_BIT = 7;
  localparam int IEN_BIT  = 7;

  function automatic logic [DW-1:0] low_mask(input int bits);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < bits) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic fld_ok(input logic [DW-1:0] v, input int bits,
                                  input int lo, input int hi);
    logic [DW-1:0] m;
    int tens;
    int units;
    int dec;
    m     = v & low_mask(bits);
    tens  = int'(m[7:4]);
    units = int'(m[3:0]);
    dec   = tens * 10 + units;
    return (units <= 9) && (dec >= lo) && (dec <= hi);
  endfunction

endpackage

// File: rtl/alarm_rst_sync.sv
module alarm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [DW-1:0]          wr_data,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [DW-1:0]          rd_data,
  output logic [NF-1:0][DW-1:0]  alm_q,
  output logic [DW-1:0]          ien_q
);
  localparam int CTRL_SEL = NF;

  logic [NF-1:0][DW-1:0] alm_d;
  logic [NF-1:0]         alm_we;
  logic [DW-1:0]         ien_d;
  logic                  ien_we;

  // per-field validation and write enable
  for (genvar f = 0; f < NF; f++) begin : g_fld
    logic hit;
    logic ok;
    assign hit = wr_en && (wr_sel == SEL_W'(f));
    assign ok  = fld_ok(wr_data, FLD_BITS[f], FLD_LO[f], FLD_HI[f]);

    always_comb begin
      alm_we[f] = hit && ok;
      alm_d[f]  = alm_we[f] ? wr_data : alm_q[f];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         alm_q[f] <= '0;
      else if (alm_we[f]) alm_q[f] <= alm_d[f];
    end
  end

  always_comb begin
    ien_we = wr_en && (wr_sel == SEL_W'(CTRL_SEL));
    ien_d  = ien_we ? wr_data : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_d;
  end

  always_comb begin
    rd_data = '0;
    for (int f = 0; f < NF; f++) begin
      if (rd_sel == SEL_W'(f)) rd_data = alm_q[f];
    end
    if (rd_sel == SEL_W'(CTRL_SEL)) rd_data = ien_q;
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import alarm_pkg::*;
(
  input  logic [NF-1:0][DW-1:0] alm_q,
  input  logic [NF-1:0][DW-1:0] cur,
  output logic                  match
);
  logic [NF-1:0] rep_mask;
  logic [NF-1:0] fld_eq;
  logic [NF-1:0] use_fld;

  for (genvar f = 0; f < NF; f++) begin : g_eq
    localparam logic [DW-1:0] LM = low_mask(FLD_BITS[f]);
    assign rep_mask[f] = alm_q[f][MASK_BIT];
    assign fld_eq[f]   = ((alm_q[f] & LM) == (cur[f] & LM));
  end

  // Masks set from the top field downward select how many low fields
  // are compared; any non-prefix pattern compares nothing.
  always_comb begin
    use_fld = '0;
    for (int k = 0; k <= NF; k++) begin
      logic [NF-1:0] pat;
      logic [NF-1:0] sel;
      pat = '0;
      sel = '0;
      for (int i = 0; i < NF; i++) begin
        if (i >= NF - k) pat[i] = 1'b1;
        if (i <  NF - k) sel[i] = 1'b1;
      end
      if (rep_mask == pat) use_fld = sel;
    end
  end

  assign match = &(fld_eq | ~use_fld);
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic enable,
  output logic irq_pulse
);
  logic irq_d;
  logic irq_q;

  always_comb irq_d = tick && match && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_pulse = irq_q;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [7:0]       rd_data,
  input  logic             tick,
  input  logic [7:0]       cur_sec,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hour,
  input  logic [7:0]       cur_date,
  output logic             irq_pulse
);
  logic                  rst_i_n;
  logic [NF-1:0][DW-1:0] alm_q;
  logic [DW-1:0]         ien_q;
  logic [NF-1:0][DW-1:0] cur;
  logic                  match;

  always_comb begin
    cur[F_SEC]  = cur_sec;
    cur[F_MIN]  = cur_min;
    cur[F_HOUR] = cur_hour;
    cur[F_DATE] = cur_date;
  end

  alarm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  alarm_regfile #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .alm_q(alm_q), .ien_q(ien_q)
  );

  alarm_compare u_cmp (
    .alm_q(alm_q), .cur(cur), .match(match)
  );

  alarm_irq_gen u_irq (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .match(match),
    .enable(ien_q[IEN_BIT]), .irq_pulse(irq_pulse)
  );
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      wr_sel,
  input logic [7:0]      wr_data,
  input logic            tick,
  input logic [7:0]      cur_sec,
  input logic            irq_pulse,
  input logic [3:0][7:0] alm_q,
  input logic [7:0]      ien_q
);
  logic sec_ok, hour_ok, date_ok, no_mask, all_mask;

  always_comb begin
    sec_ok   = (wr_data[3:0] <= 4'd9) && (wr_data[6:4] <= 3'd5);
    hour_ok  = (wr_data[3:0] <= 4'd9) &&
               ((wr_data[5:4] < 2'd2) ||
                (wr_data[5:4] == 2'd2 && wr_data[3:0] <= 4'd3));
    date_ok  = (wr_data[3:0] <= 4'd9) && (wr_data[4:0] != 5'd0);
    no_mask  = !alm_q[0][7] && !alm_q[1][7] && !alm_q[2][7] && !alm_q[3][7];
    all_mask = alm_q[0][7] && alm_q[1][7] && alm_q[2][7] && alm_q[3][7];
  end

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(tick)); // R11
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(ien_q[7])); // R12
  AST_SEC_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && !sec_ok) |=> $stable(alm_q[0])); // R2
  AST_HOUR_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2 && !hour_ok) |=> $stable(alm_q[2])); // R3
  AST_DATE_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd3 && !date_ok) |=> $stable(alm_q[3])); // R4
  AST_EVERY_TICK_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ien_q[7] && all_mask) |=> irq_pulse); // R10
  AST_MONTH_SEC_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && no_mask && cur_sec[6:0] != alm_q[0][6:0]) |=> !irq_pulse); // R6
endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
  .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .tick(tick), .cur_sec(cur_sec),
  .irq_pulse(irq_pulse), .alm_q(alm_q), .ien_q(ien_q)
);

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, tick;
  logic [2:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data, cur_sec, cur_min, cur_hour, cur_date;
  logic       irq_pulse;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alarm_match_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .irq_pulse(irq_pulse)
  );

  // {alarm sec,min,hour,date, current sec,min,hour,date, expect}
  localparam int NV = 14;
  localparam logic [64:0] VEC [NV] = '{
    {8'h30,8'h15,8'h08,8'h12, 8'h30,8'h15,8'h08,8'h12, 1'b1}, // R6 hit
    {8'h30,8'h15,8'h08,8'h12, 8'h30,8'h15,8'h08,8'h13, 1'b0}, // R6 date miss
    {8'h30,8'h15,8'h08,8'h12, 8'h31,8'h15,8'h08,8'h12, 1'b0}, // R6 sec miss
    {8'h30,8'h15,8'h08,8'h12, 8'h30,8'h15,8'h09,8'h12, 1'b0}, // R6 hour miss
    {8'h30,8'h15,8'h08,8'h92, 8'h30,8'h15,8'h08,8'h05, 1'b1}, // R7 hit
    {8'h30,8'h15,8'h08,8'h92, 8'h30,8'h15,8'h17,8'h05, 1'b0}, // R7 hour miss
    {8'h30,8'h15,8'h88,8'h92, 8'h30,8'h15,8'h17,8'h01, 1'b1}, // R8 hit
    {8'h30,8'h15,8'h88,8'h92, 8'h30,8'h16,8'h17,8'h01, 1'b0}, // R8 min miss
    {8'h30,8'h95,8'h88,8'h92, 8'h30,8'h44,8'h22,8'h28, 1'b1}, // R9 hit
    {8'h30,8'h95,8'h88,8'h92, 8'h31,8'h44,8'h22,8'h28, 1'b0}, // R9 sec miss
    {8'hB0,8'h95,8'h88,8'h92, 8'h01,8'h02,8'h03,8'h04, 1'b1}, // R10 all masks
    {8'hB0,8'h15,8'h08,8'h12, 8'h01,8'h02,8'h03,8'h04, 1'b1}, // R10 sec mask only
    {8'h30,8'h15,8'h88,8'h12, 8'h01,8'h02,8'h03,8'h04, 1'b1}, // R10 hour mask only
    {8'h30,8'h95,8'h08,8'h92, 8'h01,8'h02,8'h03,8'h04, 1'b1}  // R10 gap pattern
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    rd_sel = s;
    #1;
    d = rd_data;
  endtask

  // tick, then check the pulse in the next cycle and its release after
  task automatic pulse_chk(input string tag, input logic exp);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk({tag, " pulse"}, {7'd0, irq_pulse}, {7'd0, exp});
    @(negedge clk);
    chk({tag, " R11 release"}, {7'd0, irq_pulse}, 8'h00);
  endtask

  task automatic set_cur(input logic [7:0] s, m, h, d);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0; wr_sel = '0; wr_data = '0;
    rd_sel = '0;
    set_cur(8'h00, 8'h00, 8'h00, 8'h01);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irq_pulse}, 8'h00);

    // table walk, interrupts enabled
    wr(3'd4, 8'h80);
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VEC[i][64:57]);
      wr(3'd1, VEC[i][56:49]);
      wr(3'd2, VEC[i][48:41]);
      wr(3'd3, VEC[i][40:33]);
      set_cur(VEC[i][32:25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:1]);
      pulse_chk($sformatf("R6-R10 vector %0d", i), VEC[i][0]);
    end

    // R2 seconds/minutes validation
    wr(3'd0, 8'h45);
    wr(3'd0, 8'h60); rd(3'd0, v); chk("R2 sec 60 rejected", v, 8'h45);
    wr(3'd0, 8'h4A); rd(3'd0, v); chk("R2 sec bad digit rejected", v, 8'h45);
    wr(3'd0, 8'hD9); rd(3'd0, v); chk("R2 R5 sec 59 with mask kept", v, 8'hD9);
    wr(3'd1, 8'h59); rd(3'd1, v); chk("R2 min 59 accepted", v, 8'h59);
    wr(3'd1, 8'h7F); rd(3'd1, v); chk("R2 min 7F rejected", v, 8'h59);
    // R3 hours validation
    wr(3'd2, 8'h23); rd(3'd2, v); chk("R3 hour 23 accepted", v, 8'h23);
    wr(3'd2, 8'h24); rd(3'd2, v); chk("R3 hour 24 rejected", v, 8'h23);
    wr(3'd2, 8'h1C); rd(3'd2, v); chk("R3 hour bad digit rejected", v, 8'h23);
    // R4 date validation
    wr(3'd3, 8'h07); rd(3'd3, v); chk("R4 date 07 accepted", v, 8'h07);
    wr(3'd3, 8'h00); rd(3'd3, v); chk("R4 date 00 rejected", v, 8'h07);
    wr(3'd3, 8'h80); rd(3'd3, v); chk("R4 date mask-only rejected", v, 8'h07);
    wr(3'd3, 8'h1F); rd(3'd3, v); chk("R4 date bad digit rejected", v, 8'h07);
    wr(3'd3, 8'h31); rd(3'd3, v); chk("R4 date 31 kept exactly", v, 8'h31);

    // R5 control readback and unused selects
    wr(3'd4, 8'h5A); rd(3'd4, v); chk("R5 ctrl readback", v, 8'h5A);
    wr(3'd6, 8'hFF); rd(3'd6, v); chk("R5 unused reads zero", v, 8'h00);
    rd(3'd5, v); chk("R5 select 5 reads zero", v, 8'h00);
    rd(3'd0, v); chk("R5 unused write no effect", v, 8'hD9);

    // R12 enable gating: every-second pattern, enable clear
    wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h81);
    wr(3'd4, 8'h7F);
    pulse_chk("R12 disabled", 1'b0);
    wr(3'd4, 8'h80);
    pulse_chk("R12 enabled", 1'b1);

    // R11 no tick, no pulse, even with everything matching
    wr(3'd0, 8'h10); wr(3'd1, 8'h20); wr(3'd2, 8'h05); wr(3'd3, 8'h09);
    set_cur(8'h10, 8'h20, 8'h05, 8'h09);
    repeat (4) @(negedge clk);
    chk("R11 no tick no irq", {7'd0, irq_pulse}, 8'h00);
    pulse_chk("R11 R6 tick fires", 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule